// File: doc/BRIEF.md
# Per-Core Low-Power Mode Controller

This block moves a single CPU core of a cache-coherent cluster between its run state and four low-power states. It owns four enables: the CPU pipeline clock, the cache clock, the power switch of the CPU-plus-cache domain, and the power switch of the core's local instruction, operand and user memories. Software selects a target state with a one-cycle request. A wake-up event brings the core back to run. A coherency-participation flag tells the block whether the cache must keep answering snoops. A flush request and acknowledge pair lets an external cache controller write back dirty lines before cache power is removed.

The two clock-only states keep the domain powered. Light sleep always keeps the cache clocked, so snoops that hit dirty lines are still served while the pipeline is stopped. Plain sleep also gates the cache clock when the core has left the coherency group. Retention standby flushes the cache and then cuts CPU and cache power, but keeps the local memories powered and holding their contents. Deep standby flushes the cache, spends a fixed backup window copying the local memories out, and then switches off every domain. The backup window is why deep entry is slower than retention entry.

To leave a power-off state, the block powers the domains up first. It waits a fixed settle count with every clock still stopped, and only then restarts both clocks and reports run.

Top module: `lpm_core_ctrl`

## Requirements
- R1: After reset, the status reads run (code 0), all four enables are high and the flush request is low.
- R2: A sleep request (request code 0) received in run gives status 1 one cycle later, with the CPU clock off and both power enables on. The cache clock stays on if the coherency flag was set when the request was taken and is off if it was clear. Later changes of the flag do not alter it.
- R3: A light-sleep request (code 1) gives status 2 with the CPU clock off and the cache clock on, whatever the coherency flag, and both power enables on.
- R4: A wake event in sleep or light sleep returns the core to run on the next cycle, with both clocks on.
- R5: A retention request (code 2) or a deep request (code 3) first enters a flush wait: status 7 (busy), flush request high, CPU clock off, cache clock on, both domains powered. This lasts for as many cycles as the acknowledge takes.
- R6: The cycle after the flush acknowledge on a retention entry, status reads 3: core power off, cache clock off, local-memory power on.
- R7: On a deep entry, the flush acknowledge is followed by BACKUP_CYC busy cycles with both clocks off and both domains powered. Then status reads 4 with every enable off. Deep standby is therefore reached exactly BACKUP_CYC cycles later than retention for the same acknowledge timing, and local-memory power never drops while core power is on.
- R8: A wake event in status 3 or 4 raises both power enables on the next cycle. SETTLE_CYC busy cycles with both clocks off follow, and then status returns to run with both clocks on. No clock is ever enabled while core power is off.
- R9: A mode request taken in any state other than run has no effect on the state or on the outputs.
- R10: A wake event during the flush wait or the backup window is remembered. The core completes its entry, shows the power-off status for one cycle, and then starts the exit sequence without a further wake event.
- R11: A wake event while in run has no effect. A wake event and a request in the same run cycle enter the requested state.
- R12: A flush acknowledge outside the flush wait has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | One-cycle strobe carrying a mode request |
| mode_req | input | 2 | Requested mode: 0 sleep, 1 light sleep, 2 retention, 3 deep standby |
| wake_evt | input | 1 | Wake-up event |
| coh_member | input | 1 | Core takes part in cache coherency |
| flush_done | input | 1 | Cache flush acknowledge |
| flush_req | output | 1 | Cache flush request, held until acknowledged |
| cpu_clk_en | output | 1 | CPU pipeline clock enable |
| cache_clk_en | output | 1 | Cache clock enable |
| core_pwr_en | output | 1 | CPU and cache domain power enable |
| lmem_pwr_en | output | 1 | Local memory domain power enable |
| mode_stat | output | 3 | 0 run, 1 sleep, 2 light sleep, 3 retention, 4 deep, 7 busy |

## Verification
The bench builds the block with SETTLE_CYC = 3 and BACKUP_CYC = 4, not the production defaults. These short windows let every cycle of the settle and backup phases be checked one by one. They also make the deep-versus-retention entry difference a small exact number. The acknowledge is held back for two cycles, so the flush wait is seen to hold with power on rather than passing in one cycle. Wake events placed inside the flush wait exercise the remembered-wake path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      REQ_SLEEP  = 2'd0,
      REQ_LIGHT  = 2'd1,
      REQ_RETAIN = 2'd2,
      REQ_DEEP   = 2'd3
   } lp_req_e;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_SLEEP,
      ST_LIGHT,
      ST_FLUSH,
      ST_SAVE,
      ST_RET,
      ST_DEEP,
      ST_WAKE
   } lp_state_e;

   localparam logic [2:0] STAT_RUN    = 3'd0;
   localparam logic [2:0] STAT_SLEEP  = 3'd1;
   localparam logic [2:0] STAT_LIGHT  = 3'd2;
   localparam logic [2:0] STAT_RETAIN = 3'd3;
   localparam logic [2:0] STAT_DEEP   = 3'd4;
   localparam logic [2:0] STAT_BUSY   = 3'd7;

endpackage

// File: rtl/lpm_dwell_cnt.sv
module lpm_dwell_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   AST_CNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));                       // R8

   AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero);                                // R7

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int CW         = 4,
   parameter int SETTLE_CYC = 3,
   parameter int BACKUP_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_req_valid,
   input  logic [1:0]    mode_req,
   input  logic          wake_evt,
   input  logic          coh_member,
   input  logic          flush_done,
   input  logic          cnt_zero,
   output lp_state_e     state,
   output logic          keep_cache,
   output logic          cnt_load,
   output logic [CW-1:0] cnt_val
);

   localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] BACKUP_LD = CW'(BACKUP_CYC - 1);

   lp_state_e state_n;
   logic      tgt_deep, tgt_deep_n;
   logic      keep_n;
   logic      wpend, wpend_n;
   lp_req_e   req;

   assign req = lp_req_e'(mode_req);

   always_comb begin
      state_n    = state;
      tgt_deep_n = tgt_deep;
      keep_n     = keep_cache;
      wpend_n    = wpend;
      cnt_load   = 1'b0;
      cnt_val    = '0;
      unique case (state)
         ST_RUN: begin
            wpend_n = 1'b0;
            if (mode_req_valid) begin
               unique case (req)
                  REQ_SLEEP: begin
                     state_n = ST_SLEEP;
                     keep_n  = coh_member;
                  end
                  REQ_LIGHT:  state_n = ST_LIGHT;
                  REQ_RETAIN: begin
                     state_n    = ST_FLUSH;
                     tgt_deep_n = 1'b0;
                  end
                  REQ_DEEP: begin
                     state_n    = ST_FLUSH;
                     tgt_deep_n = 1'b1;
                  end
                  default: state_n = ST_RUN;
               endcase
            end
         end
         ST_SLEEP, ST_LIGHT: begin
            if (wake_evt) state_n = ST_RUN;
         end
         ST_FLUSH: begin
            if (wake_evt) wpend_n = 1'b1;
            if (flush_done) begin
               if (tgt_deep) begin
                  state_n  = ST_SAVE;
                  cnt_load = 1'b1;
                  cnt_val  = BACKUP_LD;
               end else begin
                  state_n  = ST_RET;
               end
            end
         end
         ST_SAVE: begin
            if (wake_evt) wpend_n = 1'b1;
            if (cnt_zero) state_n = ST_DEEP;
         end
         ST_RET, ST_DEEP: begin
            if (wake_evt || wpend) begin
               state_n  = ST_WAKE;
               wpend_n  = 1'b0;
               cnt_load = 1'b1;
               cnt_val  = SETTLE_LD;
            end
         end
         ST_WAKE: begin
            if (cnt_zero) state_n = ST_RUN;
         end
         default: state_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_RUN;
         tgt_deep   <= 1'b0;
         keep_cache <= 1'b1;
         wpend      <= 1'b0;
      end else begin
         state      <= state_n;
         tgt_deep   <= tgt_deep_n;
         keep_cache <= keep_n;
         wpend      <= wpend_n;
      end
   end

   AST_OFF_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FLUSH && !flush_done) |=> (state == ST_FLUSH));         // R5

   AST_PEND_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_RET || state == ST_DEEP) && wpend) |=> (state == ST_WAKE)); // R10

endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
   import lpm_pkg::*;
(
   input  lp_state_e  state,
   input  logic       keep_cache,
   output logic       cpu_clk_en,
   output logic       cache_clk_en,
   output logic       core_pwr_en,
   output logic       lmem_pwr_en,
   output logic       flush_req,
   output logic [2:0] mode_stat
);

   always_comb begin
      cpu_clk_en   = 1'b0;
      cache_clk_en = 1'b0;
      core_pwr_en  = 1'b1;
      lmem_pwr_en  = 1'b1;
      flush_req    = 1'b0;
      mode_stat    = STAT_BUSY;
      unique case (state)
         ST_RUN: begin
            cpu_clk_en   = 1'b1;
            cache_clk_en = 1'b1;
            mode_stat    = STAT_RUN;
         end
         ST_SLEEP: begin
            cache_clk_en = keep_cache;
            mode_stat    = STAT_SLEEP;
         end
         ST_LIGHT: begin
            cache_clk_en = 1'b1;
            mode_stat    = STAT_LIGHT;
         end
         ST_FLUSH: begin
            cache_clk_en = 1'b1;
            flush_req    = 1'b1;
         end
         ST_SAVE, ST_WAKE: begin
            mode_stat    = STAT_BUSY;
         end
         ST_RET: begin
            core_pwr_en  = 1'b0;
            mode_stat    = STAT_RETAIN;
         end
         ST_DEEP: begin
            core_pwr_en  = 1'b0;
            lmem_pwr_en  = 1'b0;
            mode_stat    = STAT_DEEP;
         end
         default: mode_stat = STAT_BUSY;
      endcase
   end

endmodule

// File: rtl/lpm_core_ctrl.sv
module lpm_core_ctrl
   import lpm_pkg::*;
#(
   parameter int SETTLE_CYC = 16,
   parameter int BACKUP_CYC = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_req_valid,
   input  logic [1:0] mode_req,
   input  logic       wake_evt,
   input  logic       coh_member,
   input  logic       flush_done,
   output logic       flush_req,
   output logic       cpu_clk_en,
   output logic       cache_clk_en,
   output logic       core_pwr_en,
   output logic       lmem_pwr_en,
   output logic [2:0] mode_stat
);

   localparam int MAXC = (SETTLE_CYC > BACKUP_CYC) ? SETTLE_CYC : BACKUP_CYC;
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end
   if (BACKUP_CYC < 1) begin : g_bad_backup
      $error("BACKUP_CYC must be at least 1");
   end

   lp_state_e     state;
   logic          keep_cache;
   logic          cnt_load;
   logic [CW-1:0] cnt_val;
   logic          cnt_zero;

   lpm_seq #(
      .CW         (CW),
      .SETTLE_CYC (SETTLE_CYC),
      .BACKUP_CYC (BACKUP_CYC)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_req_valid (mode_req_valid),
      .mode_req       (mode_req),
      .wake_evt       (wake_evt),
      .coh_member     (coh_member),
      .flush_done     (flush_done),
      .cnt_zero       (cnt_zero),
      .state          (state),
      .keep_cache     (keep_cache),
      .cnt_load       (cnt_load),
      .cnt_val        (cnt_val)
   );

   lpm_dwell_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   lpm_gate_dec u_dec (
      .state        (state),
      .keep_cache   (keep_cache),
      .cpu_clk_en   (cpu_clk_en),
      .cache_clk_en (cache_clk_en),
      .core_pwr_en  (core_pwr_en),
      .lmem_pwr_en  (lmem_pwr_en),
      .flush_req    (flush_req),
      .mode_stat    (mode_stat)
   );

   AST_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en || cache_clk_en) |-> core_pwr_en);                      // R8

   AST_LMEM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      !lmem_pwr_en |-> !core_pwr_en);                                      // R7

   AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !flush_done) |=> flush_req);                           // R5

   AST_FLUSH_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> (core_pwr_en && cache_clk_en && !cpu_clk_en));         // R5

   AST_WAKE_FROM_NAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && (mode_stat == STAT_SLEEP || mode_stat == STAT_LIGHT))
      |=> (mode_stat == STAT_RUN));                                        // R4

   AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_pwr_en) |-> (!cpu_clk_en && !cache_clk_en));              // R8

   AST_LIGHT_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == STAT_LIGHT) |-> (cache_clk_en && !cpu_clk_en));        // R3

   AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req_valid && !wake_evt && mode_stat == STAT_LIGHT)
      |=> (mode_stat == STAT_LIGHT));                                      // R9

endmodule

// File: tb/lpm_core_ctrl_tb.sv
module lpm_core_ctrl_tb;

   localparam int SETTLE = 3;
   localparam int BACKUP = 4;

   localparam logic [2:0] S_RUN = 3'd0, S_SLP = 3'd1, S_LGT = 3'd2,
                          S_RET = 3'd3, S_DEEP = 3'd4, S_BUSY = 3'd7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_req_valid = 1'b0;
   logic [1:0] mode_req = 2'd0;
   logic       wake_evt = 1'b0;
   logic       coh_member = 1'b1;
   logic       flush_done = 1'b0;
   logic       flush_req, cpu_clk_en, cache_clk_en, core_pwr_en, lmem_pwr_en;
   logic [2:0] mode_stat;

   int n_tests = 0;
   int n_fail  = 0;
   int ret_cycles = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lpm_core_ctrl #(.SETTLE_CYC(SETTLE), .BACKUP_CYC(BACKUP)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_req_valid (mode_req_valid),
      .mode_req       (mode_req),
      .wake_evt       (wake_evt),
      .coh_member     (coh_member),
      .flush_done     (flush_done),
      .flush_req      (flush_req),
      .cpu_clk_en     (cpu_clk_en),
      .cache_clk_en   (cache_clk_en),
      .core_pwr_en    (core_pwr_en),
      .lmem_pwr_en    (lmem_pwr_en),
      .mode_stat      (mode_stat)
   );

   // {cpu clk, cache clk, core pwr, lmem pwr, flush req, status}
   function automatic logic [7:0] v(logic c, logic k, logic p, logic m,
                                    logic f, logic [2:0] s);
      return {c, k, p, m, f, s};
   endfunction

   localparam logic [7:0] V_RUN = {5'b11110, S_RUN};

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_v(string tag, logic [7:0] exp);
      logic [7:0] got;
      got = {cpu_clk_en, cache_clk_en, core_pwr_en, lmem_pwr_en, flush_req, mode_stat};
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic expect_int(string tag, int got, int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic request(logic [1:0] m);
      mode_req_valid = 1'b1;
      mode_req = m;
      step();
      mode_req_valid = 1'b0;
   endtask

   task automatic pulse_wake();
      wake_evt = 1'b1;
      step();
      wake_evt = 1'b0;
   endtask

   task automatic pulse_done();
      flush_done = 1'b1;
      step();
      flush_done = 1'b0;
   endtask

   // exit from a power-off state: SETTLE busy cycles, then run
   task automatic exit_off(string tag);
      pulse_wake();
      expect_v(tag, v(0, 0, 1, 1, 0, S_BUSY));
      for (int i = 1; i < SETTLE; i++) begin
         step();
         expect_v(tag, v(0, 0, 1, 1, 0, S_BUSY));
      end
      step();
      expect_v(tag, V_RUN);
   endtask

   task automatic t_reset();
      expect_v("R1 reset state", V_RUN);
   endtask

   task automatic t_sleep();
      coh_member = 1'b1;
      request(2'd0);
      expect_v("R2 sleep coherent keeps cache clock", v(0, 1, 1, 1, 0, S_SLP));
      pulse_wake();
      expect_v("R4 wake from sleep", V_RUN);
      coh_member = 1'b0;
      request(2'd0);
      expect_v("R2 sleep non-coherent gates cache clock", v(0, 0, 1, 1, 0, S_SLP));
      coh_member = 1'b1;
      step();
      expect_v("R2 flag change after entry ignored", v(0, 0, 1, 1, 0, S_SLP));
      pulse_wake();
      expect_v("R4 wake from non-coherent sleep", V_RUN);
   endtask

   task automatic t_light();
      coh_member = 1'b0;
      request(2'd1);
      expect_v("R3 light sleep", v(0, 1, 1, 1, 0, S_LGT));
      request(2'd3);
      expect_v("R9 request in light sleep ignored", v(0, 1, 1, 1, 0, S_LGT));
      pulse_done();
      expect_v("R12 stray flush ack in light sleep", v(0, 1, 1, 1, 0, S_LGT));
      pulse_wake();
      expect_v("R4 wake from light sleep", V_RUN);
      coh_member = 1'b1;
   endtask

   task automatic t_retain();
      int cyc;
      request(2'd2);
      cyc = 1;
      expect_v("R5 flush wait", v(0, 1, 1, 1, 1, S_BUSY));
      step(); cyc++;
      step(); cyc++;
      expect_v("R5 flush wait holds power", v(0, 1, 1, 1, 1, S_BUSY));
      pulse_done(); cyc++;
      expect_v("R6 retention standby", v(0, 0, 0, 1, 0, S_RET));
      ret_cycles = cyc;
      request(2'd0);
      expect_v("R9 request in retention ignored", v(0, 0, 0, 1, 0, S_RET));
      exit_off("R8 exit from retention");
   endtask

   task automatic t_deep();
      int cyc;
      request(2'd3);
      cyc = 1;
      expect_v("R5 deep flush wait", v(0, 1, 1, 1, 1, S_BUSY));
      step(); cyc++;
      step(); cyc++;
      pulse_done(); cyc++;
      expect_v("R7 backup window powered", v(0, 0, 1, 1, 0, S_BUSY));
      for (int i = 1; i < BACKUP; i++) begin
         step(); cyc++;
         expect_v("R7 backup window powered", v(0, 0, 1, 1, 0, S_BUSY));
      end
      step(); cyc++;
      expect_v("R7 deep standby all off", v(0, 0, 0, 0, 0, S_DEEP));
      expect_int("R7 deep entry slower by backup window", cyc, ret_cycles + BACKUP);
      exit_off("R8 exit from deep standby");
   endtask

   task automatic t_pending_wake();
      request(2'd2);
      pulse_wake();
      expect_v("R10 wake during flush keeps waiting", v(0, 1, 1, 1, 1, S_BUSY));
      request(2'd1);
      expect_v("R9 request during flush ignored", v(0, 1, 1, 1, 1, S_BUSY));
      pulse_done();
      expect_v("R10 entry completes", v(0, 0, 0, 1, 0, S_RET));
      step();
      expect_v("R10 exit starts without new wake", v(0, 0, 1, 1, 0, S_BUSY));
      for (int i = 1; i < SETTLE; i++) step();
      step();
      expect_v("R10 back in run", V_RUN);
   endtask

   task automatic t_run_inputs();
      pulse_wake();
      expect_v("R11 wake in run ignored", V_RUN);
      pulse_done();
      expect_v("R12 flush ack in run ignored", V_RUN);
      wake_evt = 1'b1;
      request(2'd1);
      wake_evt = 1'b0;
      expect_v("R11 request wins over wake in run", v(0, 1, 1, 1, 0, S_LGT));
      pulse_wake();
      expect_v("R11 return to run", V_RUN);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sleep();
      t_light();
      t_retain();
      t_deep();
      t_pending_wake();
      t_run_inputs();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule